// File: doc/BRIEF.md
# Delayed Read Livelock Guard

This block arbitrates inbound transactions at a bus bridge while one read is held as a delayed transaction. A read that arrives while the block is idle cannot be served at once. The block answers it with retry and records its address and command as the delayed request. From then on, every transaction that does not match that record is turned away with retry. Each one of those rejections is counted. When the original master comes back and the read data is ready, the read is accepted and the block returns to idle.

A master can issue a read and then never come back. The bridge would then reject all other traffic for ever. To prevent this, a 3-bit limit code selects a power-of-two rejection budget between 2 and 128, or no limit at all. When the rejection count reaches the budget, the delayed read is dropped and the block is free again. The data fetch itself is handled elsewhere. This block only makes the accept, retry and discard decisions.

Top module: `dly_read_guard`

## Requirements
- R1: After reset all three decision outputs are 0, no read is delayed and the limit code is 000 (unlimited).
- R2: When no read is delayed, a started transaction with cmd_i[0]=1 (write) gives accept_o=1 in the cycle after start_i.
- R3: When no read is delayed, a started transaction with cmd_i[0]=0 (read) gives retry_o=1 in the cycle after start_i, and its address and command are recorded as the delayed read.
- R4: While a read is delayed, a started transaction whose address or command differs from the record gives retry_o=1 and increments the rejection count.
- R5: While a read is delayed, a start that matches the record with data_ready_i=0 gives retry_o=1 and leaves the rejection count unchanged.
- R6: While a read is delayed, a start that matches the record with data_ready_i=1 gives accept_o=1, frees the block and clears the count.
- R7: Limit codes 001 to 111 set a budget of 2^code rejections. The rejection that brings the count to the budget gives retry_o=1 and discard_o=1 together, and frees the block.
- R8: With limit code 000 no discard ever occurs.
- R9: After a discard the block is idle. The next read is recorded afresh and counting starts again from zero.
- R10: Each start gives exactly one of accept_o or retry_o in the next cycle. A cycle without start_i gives none of the three outputs in the next cycle.
- R11: A limit code written with cfg_we_i=1 takes effect from the next transaction onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the limit code |
| cfg_limit_i | input | 3 | Limit code: 000 unlimited, otherwise 2^code rejections |
| start_i | input | 1 | An inbound transaction starts this cycle |
| addr_i | input | 32 | Address of the starting transaction |
| cmd_i | input | 4 | Command of the starting transaction; bit 0 = 0 is a read |
| data_ready_i | input | 1 | Data for the delayed read is available |
| accept_o | output | 1 | Transaction accepted (one cycle after start) |
| retry_o | output | 1 | Transaction answered with retry (one cycle after start) |
| discard_o | output | 1 | Delayed read dropped on reaching the limit |

## Verification
The hardest case to reach is the exact edge of the rejection budget for every code. It needs a delayed read that the master never claims, and traffic from other masters that runs one short of the budget before the next rejection tips it over. The stimulus sweeps all seven codes. For each code it parks a read, sends 2^code-1 foreign transactions and checks that there is no discard, then sends one more and expects the discard. A separate sequence puts non-counting matching retries between the foreign ones, and another shows that a completed read restarts the budget. A long random phase with a small address pool mixes all cases and compares every cycle against a behavioural model.

// File: rtl/dly_guard_pkg.sv
package dly_guard_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_PEND = 1'b1} guard_state_e;

  typedef struct packed {
    logic accept;
    logic retry;
    logic discard;
  } decision_t;
endpackage

// File: rtl/dly_limit_cfg.sv
module dly_limit_cfg #(
  parameter int unsigned CODE_W = 3,
  localparam int unsigned CNT_W = 2 ** CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic              unlimited_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_q <= '0;
    else if (we_i) code_q <= code_i;
  end

  // code 0 = no limit, else 1 << code
  always_comb begin
    unlimited_o = (code_q == '0);
    limit_o     = unlimited_o ? '0 : (CNT_W'(1) << code_q);
  end

  assign code_o = code_q;
endmodule

// File: rtl/dly_tag_match.sv
module dly_tag_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CMD_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic              match_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      cmd_q  <= cmd_i;
    end
  end

  assign match_o = (addr_q == addr_i) && (cmd_q == cmd_i);
endmodule

// File: rtl/dly_rej_counter.sv
module dly_rej_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] next_o
);
  logic [CNT_W-1:0] cnt_q;

  // saturating increment
  assign next_o = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= next_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dly_read_guard.sv
module dly_read_guard
  import dly_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CMD_W      = 4,
  parameter int unsigned LIM_CODE_W = 3,
  localparam int unsigned CNT_W     = 2 ** LIM_CODE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [LIM_CODE_W-1:0] cfg_limit_i,
  input  logic                  start_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [CMD_W-1:0]      cmd_i,
  input  logic                  data_ready_i,
  output logic                  accept_o,
  output logic                  retry_o,
  output logic                  discard_o
);
  guard_state_e state_q, state_d;
  decision_t    dec_d, dec_q;

  logic [LIM_CODE_W-1:0] code_w;
  logic [CNT_W-1:0]      limit_w, cnt_w, cnt_next_w;
  logic                  unlimited_w, match_w, pend_w;
  logic                  tag_load, cnt_clr, cnt_inc, is_read;

  dly_limit_cfg #(.CODE_W(LIM_CODE_W)) u_limit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .code_i     (cfg_limit_i),
    .code_o     (code_w),
    .limit_o    (limit_w),
    .unlimited_o(unlimited_w)
  );

  dly_tag_match #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_tag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tag_load),
    .addr_i (addr_i),
    .cmd_i  (cmd_i),
    .match_o(match_w)
  );

  dly_rej_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt_w),
    .next_o(cnt_next_w)
  );

  assign is_read = ~cmd_i[0];
  assign pend_w  = (state_q == ST_PEND);

  always_comb begin
    state_d  = state_q;
    dec_d    = '0;
    tag_load = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    if (start_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (is_read) begin
            dec_d.retry = 1'b1;
            tag_load    = 1'b1;
            cnt_clr     = 1'b1;
            state_d     = ST_PEND;
          end else begin
            dec_d.accept = 1'b1;
          end
        end
        ST_PEND: begin
          if (match_w) begin
            if (data_ready_i) begin
              dec_d.accept = 1'b1;
              cnt_clr      = 1'b1;
              state_d      = ST_IDLE;
            end else begin
              dec_d.retry = 1'b1;
            end
          end else begin
            dec_d.retry = 1'b1;
            cnt_inc     = 1'b1;
            // budget spent: drop the delayed read
            if (!unlimited_w && (cnt_next_w >= limit_w)) begin
              dec_d.discard = 1'b1;
              cnt_clr       = 1'b1;
              state_d       = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dec_q   <= '0;
    end else begin
      state_q <= state_d;
      dec_q   <= dec_d;
    end
  end

  assign accept_o  = dec_q.accept;
  assign retry_o   = dec_q.retry;
  assign discard_o = dec_q.discard;
endmodule

// File: rtl/dly_read_guard_chk.sv
module dly_read_guard_chk #(
  parameter int unsigned CMD_W  = 4,
  parameter int unsigned CODE_W = 3,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CMD_W-1:0]  cmd_i,
  input logic              data_ready_i,
  input logic              accept_o,
  input logic              retry_o,
  input logic              discard_o,
  input logic              pend_i,
  input logic              match_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CODE_W-1:0] code_i
);
  // R10
  one_decision_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && retry_o));

  // R10
  quiet_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !accept_o && !retry_o && !discard_o);

  // R7
  discard_with_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> retry_o);

  // R2
  idle_write_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_i && start_i && cmd_i[0] |=> accept_o && !pend_i);

  // R3
  idle_read_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_i && start_i && !cmd_i[0] |=> retry_o && pend_i && (cnt_i == '0));

  // R5
  owner_wait_nocount_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i && start_i && match_i && !data_ready_i |=> retry_o && pend_i && $stable(cnt_i));

  // R6
  owner_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i && start_i && match_i && data_ready_i |=> accept_o && !pend_i && (cnt_i == '0));

  // R8
  unlimited_no_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == '0) |=> !discard_o);
endmodule

bind dly_read_guard dly_read_guard_chk #(
  .CMD_W (CMD_W),
  .CODE_W(LIM_CODE_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .cmd_i       (cmd_i),
  .data_ready_i(data_ready_i),
  .accept_o    (accept_o),
  .retry_o     (retry_o),
  .discard_o   (discard_o),
  .pend_i      (pend_w),
  .match_i     (match_w),
  .cnt_i       (cnt_w),
  .code_i      (code_w)
);

// File: tb/dly_read_guard_bench.sv
module dly_read_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_limit = '0;
  logic        start = 1'b0;
  logic [31:0] addr = '0;
  logic [3:0]  cmd = '0;
  logic        ready = 1'b0;
  logic        accept, retry, discard;

  int n_chk = 0;
  int n_fail = 0;
  string req = "R1";

  // reference model state
  bit          m_pend = 0;
  logic [31:0] m_addr = '0;
  logic [3:0]  m_cmd = '0;
  int          m_cnt = 0;
  int          m_code = 0;
  bit          e_acc = 0, e_ret = 0, e_dis = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_read_guard u_dly_read_guard (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_limit_i (cfg_limit),
    .start_i     (start),
    .addr_i      (addr),
    .cmd_i       (cmd),
    .data_ready_i(ready),
    .accept_o    (accept),
    .retry_o     (retry),
    .discard_o   (discard)
  );

  task automatic check_out();
    n_chk++;
    if ({accept, retry, discard} !== {e_acc, e_ret, e_dis}) begin
      n_fail++;
      $display("FAIL %s: acc/ret/dis=%b%b%b expected %b%b%b", req,
               accept, retry, discard, e_acc, e_ret, e_dis);
    end
  endtask

  task automatic model_edge();
    int lim;
    lim = (m_code == 0) ? 0 : (1 << m_code);
    e_acc = 0; e_ret = 0; e_dis = 0;
    if (start) begin
      if (!m_pend) begin
        if (cmd[0]) e_acc = 1;
        else begin
          e_ret = 1; m_pend = 1; m_addr = addr; m_cmd = cmd; m_cnt = 0;
        end
      end else if (addr == m_addr && cmd == m_cmd) begin
        if (ready) begin e_acc = 1; m_pend = 0; m_cnt = 0; end
        else e_ret = 1;
      end else begin
        e_ret = 1;
        if (m_cnt < 255) m_cnt++;
        if (lim != 0 && m_cnt >= lim) begin e_dis = 1; m_pend = 0; m_cnt = 0; end
      end
    end
    if (cfg_we) m_code = int'(cfg_limit);
  endtask

  task automatic step(input bit st, input logic [31:0] a, input logic [3:0] c,
                      input bit rdy, input bit we = 0, input logic [2:0] code = '0);
    start = st; addr = a; cmd = c; ready = rdy; cfg_we = we; cfg_limit = code;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_out();
  endtask

  task automatic set_limit(input logic [2:0] code);
    step(0, '0, '0, 0, 1, code);
  endtask

  localparam logic [3:0] RD = 4'h6;
  localparam logic [3:0] WR = 4'h7;

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: outputs quiet in reset
    repeat (3) @(negedge clk);
    check_out();
    rst_n = 1'b1;
    @(negedge clk);
    check_out();

    // R1 R8: default code is unlimited
    req = "R1";
    step(1, 32'h100, RD, 0);
    req = "R8";
    for (int i = 0; i < 300; i++) step(1, 32'h200 + i, WR, 0);
    req = "R6";
    step(1, 32'h100, RD, 1);

    req = "R2";
    step(1, 32'h300, WR, 0);
    step(1, 32'h304, 4'h3, 1);
    req = "R10";
    repeat (3) step(0, '0, '0, 0);

    // R3 R5 R7 R11: matching waits do not count
    req = "R11";
    set_limit(3'b001);
    req = "R3";
    step(1, 32'h400, RD, 0);
    req = "R5";
    step(1, 32'h400, RD, 0);
    step(1, 32'h400, RD, 0);
    req = "R4";
    step(1, 32'h500, RD, 0);
    req = "R5";
    step(1, 32'h400, RD, 0);
    step(1, 32'h400, 4'h4, 1);
    req = "R7";
    step(1, 32'h500, WR, 0);

    // R9: block free after discard, old owner now a stranger
    req = "R9";
    step(1, 32'h600, 4'h2, 0);
    step(1, 32'h400, RD, 1);
    step(1, 32'h600, 4'h2, 1);
    step(1, 32'h700, WR, 0);

    // R7: every code, one short then the edge
    for (int c = 1; c < 8; c++) begin
      req = "R7";
      set_limit(3'(c));
      step(1, 32'h1000 + c, RD, 0);
      for (int k = 0; k < (1 << c) - 1; k++) step(1, 32'h2000 + k, WR, 0);
      step(1, 32'h3000, RD, 0);
    end

    // R6: completion restarts the budget
    req = "R6";
    set_limit(3'b010);
    step(1, 32'h800, RD, 0);
    repeat (3) step(1, 32'h900, WR, 0);
    step(1, 32'h800, RD, 1);
    step(1, 32'h810, RD, 0);
    repeat (3) step(1, 32'h900, WR, 0);
    step(1, 32'h900, WR, 0);

    // R11: write while pending, new code used on next transaction
    req = "R11";
    step(1, 32'hA00, RD, 0);
    step(1, 32'hB00, WR, 0, 1, 3'b001);
    step(1, 32'hB00, WR, 0);
    set_limit(3'b000);

    // R10: random mix against the model
    req = "R10";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 80, 32'($urandom_range(0, 3)) << 2, 4'($urandom_range(6, 7)),
           bit'($urandom_range(0, 1)), r > 96, 3'($urandom_range(0, 3)));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule